// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block is a synchronous supervisor for a processor subsystem. It drives an active-low system reset and an active-low watchdog fault. Both are registered levels, and both rest high when inactive, as an open-drain line with a pull-up would. The reset asserts while a qualified supply-good flag is low or while an active-low manual reset input is held. After the last such cause clears, the reset stays low for a fixed number of clock cycles.

Once reset has released, the block watches a kick input. Only a falling edge on that input, taken after a two-flop synchronizer, restarts the watchdog window. If a whole window passes with no such edge, the fault output pulses low for the same fixed number of cycles as the reset delay. A fresh window then starts. An enable-select input turns the watchdog off. A timeout-select input chooses between a standard window and an extended window. All three durations are parameters counted in clock cycles.

Top module: `wdt_supervisor`

## Requirements
- R1: A low `supply_ok_i` drives `sys_rst_n_o` low on the next clock edge. After `supply_ok_i` returns high, `sys_rst_n_o` goes high exactly RST_DELAY cycles later, provided no other cause is active.
- R2: `man_rst_n_i` passes through a two-flop synchronizer. A low level asserts reset 3 cycles after it is applied. After it returns high, reset releases 2 + RST_DELAY cycles later.
- R3: Only a falling edge of the synchronized kick restarts the window. A kick edge applied in cycle k restarts the window so that a timeout without further kicks falls in cycle k + 3 + window length. Rising edges and steady levels have no effect.
- R4: With `tmo_sel_i` = 0, a timeout fires TMO_STD cycles after the window was last restarted, and `wd_fault_n_o` goes low.
- R5: A fault pulse keeps `wd_fault_n_o` low for exactly RST_DELAY cycles, unless reset cuts it short.
- R6: `wd_fault_n_o` is high whenever `sys_rst_n_o` is low. When reset asserts during a fault pulse, the fault output goes high in the same cycle that reset goes low.
- R7: Kick edges that fall while reset is low, or while the fault output is low, are ignored.
- R8: With `wd_en_i` = 0, no timeout is generated and the window count is held at zero.
- R9: With `tmo_sel_i` = 1, the window length is TMO_EXT cycles.
- R10: The window restarts from zero on the cycle that reset releases and on the cycle that a fault pulse ends. With no kicks, the next timeout therefore follows a full window later.
- R11: While `rst_n` is low, `sys_rst_n_o` is low and `wd_fault_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor logic |
| supply_ok_i | input | 1 | Qualified supply-good level, high when supply is in range |
| man_rst_n_i | input | 1 | Asynchronous manual reset request, active low |
| kick_i | input | 1 | Asynchronous watchdog kick; a falling edge restarts the window |
| wd_en_i | input | 1 | Watchdog enable; low disables timeouts |
| tmo_sel_i | input | 1 | Window select: 0 standard, 1 extended |
| sys_rst_n_o | output | 1 | System reset, active low |
| wd_fault_n_o | output | 1 | Watchdog fault pulse, active low |

## Verification
The hardest case to reach is a reset that arrives in the middle of a fault pulse. Reaching it needs a timeout, then a manual reset placed a few cycles into the pulse while allowing for the synchronizer delay. The check confirms that both outputs change on the same edge and that a full window follows the release. The bench reaches this case by counting cycles from a known enable point, so it knows where the pulse lies. It schedules each expected output change with its exact cycle. A kick inside a fault pulse and a kick during supply loss are also placed at computed cycles, to show that neither moves the next timeout.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
    typedef enum logic {
        WIN_STD = 1'b0,
        WIN_EXT = 1'b1
    } win_sel_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
    parameter int N       = 2,
    parameter int STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] stg_q [STAGES];
    logic [N-1:0] stg_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stg_d[s] = d_i;
            end else begin : g_next
                assign stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdsup_rst_ctrl.sv
module wdsup_rst_ctrl #(
    parameter int RST_DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic mr_n_i,
    output logic rel_o,
    output logic rel_next_o
);
    localparam int CW = $clog2(RST_DELAY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rel;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_ok_i || !mr_n_i) begin
            st_d.cnt = '0;
            st_d.rel = 1'b0;
        end else if (!st_q.rel) begin
            if (st_q.cnt == CW'(RST_DELAY - 1)) begin
                st_d.rel = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rel_o      = st_q.rel;
    assign rel_next_o = st_d.rel;
endmodule

// File: rtl/wdsup_wd_core.sv
module wdsup_wd_core
    import wdsup_pkg::*;
#(
    parameter int RST_DELAY = 16,
    parameter int TMO_STD   = 40,
    parameter int TMO_EXT   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_i,
    input  logic rel_next_i,
    input  logic kick_s_i,
    input  logic en_i,
    input  logic sel_i,
    output logic fault_n_o
);
    localparam int WW = $clog2(max2(TMO_STD, TMO_EXT) + 1);
    localparam int PW = $clog2(RST_DELAY + 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [PW-1:0] pulse;
        logic          fault;
        logic          kick_prev;
    } st_t;

    st_t           st_d, st_q;
    logic          kick_fall;
    logic [WW-1:0] win_last;
    win_sel_e      win_sel;

    assign win_sel   = win_sel_e'(sel_i);
    assign win_last  = (win_sel == WIN_EXT) ? WW'(TMO_EXT - 1) : WW'(TMO_STD - 1);
    assign kick_fall = st_q.kick_prev & ~kick_s_i;

    always_comb begin
        st_d           = st_q;
        st_d.kick_prev = kick_s_i;
        if (!rel_i || !rel_next_i) begin
            st_d.win   = '0;
            st_d.pulse = '0;
            st_d.fault = 1'b0;
        end else if (st_q.fault) begin
            if (st_q.pulse == PW'(RST_DELAY - 1)) begin
                st_d.fault = 1'b0;
                st_d.pulse = '0;
                st_d.win   = '0;
            end else begin
                st_d.pulse = st_q.pulse + 1'b1;
            end
        end else if (!en_i || kick_fall) begin
            st_d.win = '0;
        end else if (st_q.win == win_last) begin
            st_d.fault = 1'b1;
            st_d.win   = '0;
            st_d.pulse = '0;
        end else begin
            st_d.win = st_q.win + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{win: '0, pulse: '0, fault: 1'b0, kick_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign fault_n_o = ~st_q.fault;
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
    parameter int RST_DELAY   = 16,
    parameter int TMO_STD     = 40,
    parameter int TMO_EXT     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic man_rst_n_i,
    input  logic kick_i,
    input  logic wd_en_i,
    input  logic tmo_sel_i,
    output logic sys_rst_n_o,
    output logic wd_fault_n_o
);
    logic [1:0] async_in;
    logic [1:0] sync_out;
    logic       rel, rel_next;

    assign async_in = {man_rst_n_i, kick_i};

    wdsup_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (async_in),
        .q_o   (sync_out)
    );

    wdsup_rst_ctrl #(.RST_DELAY(RST_DELAY)) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .mr_n_i      (sync_out[1]),
        .rel_o       (rel),
        .rel_next_o  (rel_next)
    );

    wdsup_wd_core #(.RST_DELAY(RST_DELAY), .TMO_STD(TMO_STD), .TMO_EXT(TMO_EXT)) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel_i      (rel),
        .rel_next_i (rel_next),
        .kick_s_i   (sync_out[0]),
        .en_i       (wd_en_i),
        .sel_i      (tmo_sel_i),
        .fault_n_o  (wd_fault_n_o)
    );

    assign sys_rst_n_o = rel;
endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker #(
    parameter int RST_DELAY = 16
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok_i,
    input logic man_rst_n_i,
    input logic wd_en_i,
    input logic sys_rst_n_o,
    input logic wd_fault_n_o
);
    int low_run;
    int ok_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
            ok_run  <= 0;
        end else begin
            low_run <= wd_fault_n_o ? 0 : low_run + 1;
            ok_run  <= (supply_ok_i && man_rst_n_i) ? ok_run + 1 : 0;
        end
    end

    // R6
    a_r6_fault_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n_o |-> wd_fault_n_o);

    // R1
    a_r1_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !sys_rst_n_o);

    // R8
    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en_i && wd_fault_n_o) |=> wd_fault_n_o);

    // R5
    a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wd_fault_n_o) && sys_rst_n_o) |-> (low_run == RST_DELAY));

    // R2
    a_r2_release_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n_o) |-> (ok_run >= RST_DELAY));
endmodule

bind wdt_supervisor wdsup_checker #(.RST_DELAY(RST_DELAY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok_i),
    .man_rst_n_i  (man_rst_n_i),
    .wd_en_i      (wd_en_i),
    .sys_rst_n_o  (sys_rst_n_o),
    .wd_fault_n_o (wd_fault_n_o)
);

// File: tb/sim_wdt_supervisor.sv
`timescale 1ns/1ps
module sim_wdt_supervisor;
    localparam int RD  = 16;
    localparam int STD = 40;
    localparam int EXT = 100;

    logic clk = 1'b0;
    logic rst_n, supply_ok, mr_n, kick, en, sel;
    logic sys_rst_n, fault_n;

    always #2 clk = ~clk;

    wdt_supervisor #(.RST_DELAY(RD), .TMO_STD(STD), .TMO_EXT(EXT)) u0 (
        .clk (clk), .rst_n (rst_n), .supply_ok_i (supply_ok), .man_rst_n_i (mr_n),
        .kick_i (kick), .wd_en_i (en), .tmo_sel_i (sel),
        .sys_rst_n_o (sys_rst_n), .wd_fault_n_o (fault_n)
    );

    typedef struct {
        int    cyc;
        bit    r;
        bit    f;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 0;
    bit   done = 0;
    logic prev_r, prev_f;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int c, input bit r, input bit f, input string tag);
        exp_t e;
        e.cyc = c; e.r = r; e.f = f; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: every output change is matched against the scoreboard head
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (sys_rst_n !== prev_r || fault_n !== prev_f) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected change cyc=%0d rst=%b fault=%b expected no change",
                             cyc, sys_rst_n, fault_n);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.cyc != cyc || e.r !== sys_rst_n || e.f !== fault_n) begin
                        errors++;
                        $display("FAIL %s actual cyc=%0d rst=%b fault=%b expected cyc=%0d rst=%b fault=%b",
                                 e.tag, cyc, sys_rst_n, fault_n, e.cyc, e.r, e.f);
                    end
                end
            end
            prev_r = sys_rst_n;
            prev_f = fault_n;
        end
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        int d, rel, kl, f1, e1, e2, m, r, s;
        rst_n = 0; supply_ok = 0; mr_n = 1; kick = 1; en = 1; sel = 0;
        repeat (4) @(negedge clk);
        // R11 reset state
        checks++;
        if (sys_rst_n !== 1'b0 || fault_n !== 1'b1) begin
            errors++;
            $display("FAIL R11 actual rst=%b fault=%b expected rst=0 fault=1", sys_rst_n, fault_n);
        end
        rst_n = 1;
        prev_r = sys_rst_n; prev_f = fault_n;
        mon_on = 1;
        @(negedge clk);

        // R1 release after supply good
        d = cyc; supply_ok = 1;
        rel = d + RD;
        push(rel, 1, 1, "R1");
        wait_to(rel + 10);

        // R3 kicks within the window keep it alive; a held low level does not
        kl = cyc;
        for (int i = 0; i < 5; i++) begin
            kl = cyc; kick = 0;
            wait_to(kl + 3); kick = 1;
            wait_to(kl + 30);
        end
        f1 = kl + 3 + STD;
        push(f1, 1, 0, "R3/R4");
        e1 = f1 + RD;
        push(e1, 1, 1, "R5");
        // R7 kick inside the fault pulse is ignored
        wait_to(f1 + 3); kick = 0;
        wait_to(f1 + 6); kick = 1;
        push(e1 + STD, 1, 0, "R10");
        e2 = e1 + STD + RD;
        push(e2, 1, 1, "R5");
        wait_to(e2 + 1); en = 0;
        // R8 disabled: kicks and time pass with no event
        wait_to(e2 + 60); kick = 0;
        wait_to(e2 + 64); kick = 1;
        wait_to(e2 + 200);

        // R9 extended window
        d = cyc; en = 1; sel = 1;
        push(d + EXT, 1, 0, "R9");
        push(d + EXT + RD, 1, 1, "R9");
        wait_to(d + EXT + RD + 1); en = 0; sel = 0;
        wait_to(cyc + 20);

        // R6 manual reset during a fault pulse, R2 release, R10 fresh window
        d = cyc; en = 1;
        push(d + STD, 1, 0, "R4");
        wait_to(d + STD + 5); mr_n = 0; m = cyc;
        push(m + 3, 0, 1, "R6");
        wait_to(m + 10); mr_n = 1;
        r = m + 10 + 2 + RD;
        push(r, 1, 1, "R2");
        push(r + STD, 1, 0, "R10");
        push(r + STD + RD, 1, 1, "R5");
        wait_to(r + STD + RD + 1); en = 0;
        wait_to(cyc + 5);

        // R1 supply loss, R7 kick during reset ignored
        d = cyc; supply_ok = 0; en = 1;
        push(d + 1, 0, 1, "R1");
        wait_to(d + 8); kick = 0;
        wait_to(d + 10); kick = 1;
        wait_to(d + 12); supply_ok = 1; s = cyc;
        push(s + RD, 1, 1, "R1");
        push(s + RD + STD, 1, 0, "R7");
        push(s + RD + STD + RD, 1, 1, "R5");
        wait_to(s + RD + STD + RD + 1); en = 0;
        wait_to(cyc + 30);

        done = 1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s actual missing=%0d expected missing=0 (cyc %0d)",
                     exp_q[0].tag, exp_q.size(), exp_q[0].cyc);
        end
        summary();
    end
endmodule